// File: doc/BRIEF.md
# Miss Reservation Buffer

This block parks cache requests that missed in a pipelined cache bank, or were made to miss so that requests to one line finish in order, until the line they need has been brought in. The final pipeline stage writes a missed request into a free slot together with everything needed to replay it later. A slot may enter the buffer already eligible for replay. It enters that way when the request did not really miss, or when a fill for its line is already on its way down the pipeline. When a fill for a line is accepted at the head of the pipeline, every parked request for that line becomes eligible at once.

The head of the pipeline can ask at any time whether an incoming line address collides with a parked request. When it asserts the schedule strobe, the buffer hands over its oldest eligible request. That slot then stays reserved but marked as in flight, so it cannot be handed out twice. When the replay reaches the last stage, one of two things happens. A retire strobe frees the slot if the replay hit. A re-park enqueue returns the slot to waiting if the replay missed again; this uses no second slot. Replays complete in the order they were handed out.

Top module: `miss_resv_buf`

## Requirements
- R1: After reset the buffer holds no request: `out_valid`, `full`, `almost_full` and `hazard` are all 0.
- R2: A stored request presents, when scheduled, exactly the line address, word select, write word, thread id, tag, write flag, byte enables, snoop flag and snoop-invalidate flag it was enqueued with.
- R3: A new request enqueued with `enq_is_ready`=1 is offered on `out_valid` from the next cycle. One enqueued with `enq_is_ready`=0 is not offered until a matching fill arrives.
- R4: A cycle with `fill_valid`=1 makes every stored request whose line address equals `fill_addr` eligible. Requests for other lines are left untouched.
- R5: A new request (or a re-parked one) whose line equals `fill_addr` in a cycle with `fill_valid`=1 is stored eligible.
- R6: `hazard` is 1 exactly when `look_addr` equals the line address of any occupied slot, in flight or waiting, in the same cycle.
- R7: `full` is 1 when all DEPTH slots are occupied. `almost_full` is 1 when at least DEPTH-ALMOST_GAP slots are occupied. A new-request enqueue while `full` is 1 is dropped.
- R8: Among eligible requests that are not in flight, the one enqueued earliest is offered.
- R9: A request handed out by `sched` while `out_valid`=1 is not offered again while it is in flight.
- R10: `retire` frees the in-flight slot that was handed out earliest.
- R11: An enqueue with `enq_replay`=1 does not allocate. It returns the earliest-handed-out in-flight slot to waiting, with its eligibility taken from `enq_is_ready` (or from a same-cycle matching fill).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Enqueue strobe from the last stage |
| enq_replay | input | 1 | Enqueue is a replay that missed again (re-park) |
| enq_is_ready | input | 1 | Store the request as eligible at once |
| enq_addr | input | ADDR_W | Line address |
| enq_wsel | input | WSEL_W | Word select |
| enq_data | input | WORD_W | Write word |
| enq_tid | input | TID_W | Requester thread id |
| enq_tag | input | TAG_W | Request tag |
| enq_wr | input | 1 | Write flag |
| enq_byteen | input | BE_W | Byte enables |
| enq_snoop | input | 1 | Snoop flag |
| enq_snoop_inv | input | 1 | Snoop-invalidate flag |
| full | output | 1 | All slots occupied |
| almost_full | output | 1 | Occupancy at or above DEPTH-ALMOST_GAP |
| fill_valid | input | 1 | Fill accepted at stage 0 |
| fill_addr | input | ADDR_W | Line address of the fill |
| look_addr | input | ADDR_W | Stage-0 lookup address |
| hazard | output | 1 | Lookup address matches an occupied slot |
| sched | input | 1 | Take the offered request for replay |
| out_valid | output | 1 | An eligible request is offered |
| out_addr | output | ADDR_W | Offered line address |
| out_wsel | output | WSEL_W | Offered word select |
| out_data | output | WORD_W | Offered write word |
| out_tid | output | TID_W | Offered thread id |
| out_tag | output | TAG_W | Offered tag |
| out_wr | output | 1 | Offered write flag |
| out_byteen | output | BE_W | Offered byte enables |
| out_snoop | output | 1 | Offered snoop flag |
| out_snoop_inv | output | 1 | Offered snoop-invalidate flag |
| retire | input | 1 | Replay completed without a miss: free its slot |

## Verification
A fill update and an enqueue can land in the same cycle, for the same line or for different lines. A fill can also coincide with a re-park of an in-flight slot. The stimulus provokes these collisions by drawing fill and enqueue line addresses from a pool of only four lines, and it adds directed cycles that pair a fill with a new request to its own line. The outcome is judged one cycle later, on whether that request is offered and in which age order, against a bench model of occupancy, eligibility and the in-flight order.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mrb_addr_match.sv
module mrb_addr_match #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 8
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] tab,
   input  logic [ADDR_W-1:0]            key,
   input  logic [DEPTH-1:0]             mask,
   output logic [DEPTH-1:0]             hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = mask[g] && (tab[g] == key);
   end
endmodule

// File: rtl/mrb_age_order.sv
module mrb_age_order #(
   parameter int DEPTH = 4
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  alloc_en,
   input  logic [mrb_pkg::idx_width(DEPTH)-1:0]  alloc_idx,
   input  logic [DEPTH-1:0]                      cand,
   output logic [DEPTH-1:0]                      grant
);
   // older_q[a][b] set: slot a was allocated before slot b
   logic [DEPTH-1:0][DEPTH-1:0] older_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         older_q <= '0;
      end else if (alloc_en) begin
         for (int j = 0; j < DEPTH; j++) begin
            older_q[alloc_idx][j] <= 1'b0;
            if (j != int'(alloc_idx)) older_q[j][alloc_idx] <= 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         logic beaten;
         beaten = 1'b0;
         for (int j = 0; j < DEPTH; j++)
            if (j != i && cand[j] && older_q[j][i]) beaten = 1'b1;
         grant[i] = cand[i] && !beaten;
      end
   end
endmodule

// File: rtl/mrb_idx_fifo.sv
module mrb_idx_fifo #(
   parameter int DEPTH = 4
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  push,
   input  logic [mrb_pkg::idx_width(DEPTH)-1:0]  push_idx,
   input  logic                                  pop,
   output logic [mrb_pkg::idx_width(DEPTH)-1:0]  head_idx,
   output logic                                  not_empty
);
   localparam int IW = mrb_pkg::idx_width(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [IW-1:0] slot_q [DEPTH];
   logic [IW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
      return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign head_idx  = slot_q[rd_q];
   assign not_empty = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
         if (push) begin
            slot_q[wr_q] <= push_idx;
            wr_q         <= bump(wr_q);
         end
         if (pop) rd_q <= bump(rd_q);
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/miss_resv_buf.sv
module miss_resv_buf #(
   parameter int DEPTH      = 4,
   parameter int ALMOST_GAP = 1,
   parameter int ADDR_W     = 8,
   parameter int WSEL_W     = 2,
   parameter int WORD_W     = 32,
   parameter int TID_W      = 2,
   parameter int TAG_W      = 6,
   parameter int BE_W       = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enq_valid,
   input  logic              enq_replay,
   input  logic              enq_is_ready,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [WSEL_W-1:0] enq_wsel,
   input  logic [WORD_W-1:0] enq_data,
   input  logic [TID_W-1:0]  enq_tid,
   input  logic [TAG_W-1:0]  enq_tag,
   input  logic              enq_wr,
   input  logic [BE_W-1:0]   enq_byteen,
   input  logic              enq_snoop,
   input  logic              enq_snoop_inv,
   output logic              full,
   output logic              almost_full,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              hazard,
   input  logic              sched,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [WSEL_W-1:0] out_wsel,
   output logic [WORD_W-1:0] out_data,
   output logic [TID_W-1:0]  out_tid,
   output logic [TAG_W-1:0]  out_tag,
   output logic              out_wr,
   output logic [BE_W-1:0]   out_byteen,
   output logic              out_snoop,
   output logic              out_snoop_inv,
   input  logic              retire
);
   localparam int IW = mrb_pkg::idx_width(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("miss_resv_buf: DEPTH must be at least 2");
   end
   if (ALMOST_GAP < 0 || ALMOST_GAP >= DEPTH) begin : g_bad_gap
      $error("miss_resv_buf: ALMOST_GAP must lie in 0..DEPTH-1");
   end

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [WSEL_W-1:0] wsel;
      logic [WORD_W-1:0] data;
      logic [TID_W-1:0]  tid;
      logic [TAG_W-1:0]  tag;
      logic              wr;
      logic [BE_W-1:0]   byteen;
      logic              snoop;
      logic              snoop_inv;
   } slot_t;

   slot_t            ent_q [DEPTH];
   logic [DEPTH-1:0] used_q, elig_q, infl_q;

   logic [DEPTH-1:0][ADDR_W-1:0] addr_tab;
   logic [DEPTH-1:0] fill_hit, look_hit, cand, grant;
   logic [IW-1:0]    sel_idx, free_idx, head_idx;
   logic [CW-1:0]    occ;
   logic             fifo_ne, do_sched, do_free, do_repark, do_alloc, new_same_line;
   slot_t            new_ent;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) addr_tab[i] = ent_q[i].addr;
   end

   mrb_addr_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fill_cmp (
      .tab(addr_tab), .key(fill_addr), .mask(used_q & {DEPTH{fill_valid}}), .hit(fill_hit));

   mrb_addr_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_look_cmp (
      .tab(addr_tab), .key(look_addr), .mask(used_q), .hit(look_hit));

   assign cand = used_q & elig_q & ~infl_q;

   mrb_age_order #(.DEPTH(DEPTH)) u_age (
      .clk(clk), .rst(rst), .alloc_en(do_alloc), .alloc_idx(free_idx),
      .cand(cand), .grant(grant));

   mrb_idx_fifo #(.DEPTH(DEPTH)) u_inflight (
      .clk(clk), .rst(rst), .push(do_sched), .push_idx(sel_idx),
      .pop(do_free || do_repark), .head_idx(head_idx), .not_empty(fifo_ne));

   always_comb begin
      sel_idx  = '0;
      free_idx = '0;
      occ      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) sel_idx = sel_idx | IW'(i);
         occ = occ + CW'(used_q[i]);
      end
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!used_q[i]) free_idx = IW'(i);
   end

   assign full        = (occ == CW'(DEPTH));
   assign almost_full = (occ >= CW'(DEPTH - ALMOST_GAP));
   assign hazard      = |look_hit;
   assign out_valid   = |cand;

   assign {out_addr, out_wsel, out_data, out_tid, out_tag, out_wr,
           out_byteen, out_snoop, out_snoop_inv} = ent_q[sel_idx];

   assign do_sched      = sched && out_valid;
   assign do_free       = retire && fifo_ne;
   assign do_repark     = enq_valid && enq_replay && fifo_ne && !retire;
   assign do_alloc      = enq_valid && !enq_replay && !full;
   assign new_same_line = fill_valid && (fill_addr == enq_addr);
   assign new_ent       = '{enq_addr, enq_wsel, enq_data, enq_tid, enq_tag,
                            enq_wr, enq_byteen, enq_snoop, enq_snoop_inv};

   always_ff @(posedge clk) begin
      if (rst) begin
         used_q <= '0;
         elig_q <= '0;
         infl_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (fill_hit[i]) elig_q[i] <= 1'b1;
            if (do_sched && sel_idx == IW'(i)) infl_q[i] <= 1'b1;
            if (do_repark && head_idx == IW'(i)) begin
               infl_q[i] <= 1'b0;
               elig_q[i] <= enq_is_ready || fill_hit[i];
            end
            if (do_free && head_idx == IW'(i)) begin
               used_q[i] <= 1'b0;
               elig_q[i] <= 1'b0;
               infl_q[i] <= 1'b0;
            end
            if (do_alloc && free_idx == IW'(i)) begin
               used_q[i] <= 1'b1;
               elig_q[i] <= enq_is_ready || new_same_line;
               infl_q[i] <= 1'b0;
               ent_q[i]  <= new_ent;
            end
         end
      end
   end
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker (
   input logic clk,
   input logic rst,
   input logic full,
   input logic almost_full,
   input logic retire,
   input logic out_valid,
   input logic hazard
);
   // R1
   reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !full && !almost_full && !hazard));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (full && !retire) |=> full);

   // R7
   full_implies_almost_chk: assert property (@(posedge clk) disable iff (rst)
      full |-> almost_full);

   // R10
   retire_frees_chk: assert property (@(posedge clk) disable iff (rst)
      (full && retire) |=> !full);
endmodule

bind miss_resv_buf mrb_checker u_mrb_checker (
   .clk(clk), .rst(rst), .full(full), .almost_full(almost_full),
   .retire(retire), .out_valid(out_valid), .hazard(hazard));

// File: tb/tb_miss_resv_buf.sv
module tb_miss_resv_buf;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4, GAP = 1, AW = 8, SW = 2, DW = 32, TW = 2, GW = 6, BW = 4;
   localparam int FW = AW + SW + DW + TW + GW + 1 + BW + 1 + 1;

   logic clk = 1'b0, rst = 1'b1;
   logic enq_valid, enq_replay, enq_is_ready, enq_wr, enq_snoop, enq_snoop_inv;
   logic [AW-1:0] enq_addr, fill_addr, look_addr;
   logic [SW-1:0] enq_wsel;
   logic [DW-1:0] enq_data;
   logic [TW-1:0] enq_tid;
   logic [GW-1:0] enq_tag;
   logic [BW-1:0] enq_byteen;
   logic fill_valid, sched, retire;
   logic full, almost_full, hazard, out_valid, out_wr, out_snoop, out_snoop_inv;
   logic [AW-1:0] out_addr;
   logic [SW-1:0] out_wsel;
   logic [DW-1:0] out_data;
   logic [TW-1:0] out_tid;
   logic [GW-1:0] out_tag;
   logic [BW-1:0] out_byteen;

   miss_resv_buf #(.DEPTH(DEPTH), .ALMOST_GAP(GAP), .ADDR_W(AW), .WSEL_W(SW), .WORD_W(DW),
                   .TID_W(TW), .TAG_W(GW), .BE_W(BW)) dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   // bench model
   bit          m_used [DEPTH], m_elig [DEPTH], m_infl [DEPTH];
   int          m_seq  [DEPTH];
   logic [AW-1:0] m_addr [DEPTH];
   logic [FW-1:0] m_fld  [DEPTH];
   int          m_q[$];
   int          seq_ctr = 0;
   int          e_sel;

   always @(posedge clk) cycles <= cycles + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int m_count();
      int c = 0;
      for (int i = 0; i < DEPTH; i++) if (m_used[i]) c++;
      return c;
   endfunction

   function automatic int m_pick();
      int best = -1;
      for (int i = 0; i < DEPTH; i++)
         if (m_used[i] && m_elig[i] && !m_infl[i])
            if (best < 0 || m_seq[i] < m_seq[best]) best = i;
      return best;
   endfunction

   function automatic bit m_hazard(input logic [AW-1:0] a);
      for (int i = 0; i < DEPTH; i++) if (m_used[i] && m_addr[i] == a) return 1'b1;
      return 1'b0;
   endfunction

   task automatic clear_in();
      {enq_valid, enq_replay, enq_is_ready, enq_wr, enq_snoop, enq_snoop_inv} = '0;
      enq_addr = '0; enq_wsel = '0; enq_data = '0; enq_tid = '0; enq_tag = '0; enq_byteen = '0;
      fill_valid = 1'b0; fill_addr = '0; look_addr = '0; sched = 1'b0; retire = 1'b0;
   endtask

   task automatic new_req(input logic [AW-1:0] a, input bit rdy);
      enq_valid = 1'b1; enq_replay = 1'b0; enq_is_ready = rdy; enq_addr = a;
      enq_wsel = SW'($urandom); enq_data = $urandom; enq_tid = TW'($urandom);
      enq_tag = GW'($urandom); enq_wr = 1'($urandom); enq_byteen = BW'($urandom);
      enq_snoop = 1'($urandom); enq_snoop_inv = 1'($urandom);
   endtask

   // sample combinational outputs mid-cycle against the model
   task automatic settle(input string tag);
      int n;
      #1;
      n = m_count();
      e_sel = m_pick();
      chk(full == (n == DEPTH), "R7", {tag, " full"}, FW'(full), FW'(n == DEPTH));
      chk(almost_full == (n >= DEPTH - GAP), "R7", {tag, " almost_full"}, FW'(almost_full), FW'(n >= DEPTH - GAP));
      chk(hazard == m_hazard(look_addr), "R6", {tag, " hazard"}, FW'(hazard), FW'(m_hazard(look_addr)));
      chk(out_valid == (e_sel >= 0), "R8", {tag, " out_valid"}, FW'(out_valid), FW'(e_sel >= 0));
      if (e_sel >= 0)
         chk({out_addr, out_wsel, out_data, out_tid, out_tag, out_wr, out_byteen, out_snoop, out_snoop_inv}
             == m_fld[e_sel], "R2", {tag, " offered fields"},
             {out_addr, out_wsel, out_data, out_tid, out_tag, out_wr, out_byteen, out_snoop, out_snoop_inv},
             m_fld[e_sel]);
   endtask

   task automatic tick();
      int  qh, slot;
      bit  dfree, drep, dalloc, fhit_q;
      @(posedge clk);
      qh     = (m_q.size() > 0) ? m_q[0] : -1;
      dfree  = retire && qh >= 0;
      drep   = enq_valid && enq_replay && qh >= 0 && !retire;
      dalloc = enq_valid && !enq_replay && m_count() < DEPTH;
      slot = -1;
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_used[i]) slot = i;
      fhit_q = (qh >= 0) && fill_valid && m_addr[qh] == fill_addr;
      for (int i = 0; i < DEPTH; i++)
         if (m_used[i] && fill_valid && m_addr[i] == fill_addr) m_elig[i] = 1'b1;
      if (dfree) begin
         void'(m_q.pop_front());
         m_used[qh] = 1'b0; m_elig[qh] = 1'b0; m_infl[qh] = 1'b0;
      end
      if (drep) begin
         void'(m_q.pop_front());
         m_infl[qh] = 1'b0; m_elig[qh] = enq_is_ready || fhit_q;
      end
      if (sched && e_sel >= 0) begin
         m_infl[e_sel] = 1'b1;
         m_q.push_back(e_sel);
      end
      if (dalloc) begin
         m_used[slot] = 1'b1; m_infl[slot] = 1'b0;
         m_elig[slot] = enq_is_ready || (fill_valid && fill_addr == enq_addr);
         m_seq[slot]  = seq_ctr++;
         m_addr[slot] = enq_addr;
         m_fld[slot]  = {enq_addr, enq_wsel, enq_data, enq_tid, enq_tag, enq_wr,
                         enq_byteen, enq_snoop, enq_snoop_inv};
      end
   endtask

   task automatic begin_cyc();
      @(negedge clk);
      clear_in();
   endtask

   initial begin : watchdog
      while (!done && cycles < 100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=done", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd24680));
      clear_in();
      for (int i = 0; i < DEPTH; i++) begin
         m_used[i] = 0; m_elig[i] = 0; m_infl[i] = 0; m_seq[i] = 0; m_addr[i] = '0; m_fld[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1: empty after reset
      begin_cyc(); settle("R1");
      chk(!out_valid && !full && !almost_full && !hazard, "R1", "reset state",
          FW'({out_valid, full, almost_full, hazard}), '0);
      tick();

      // fill the buffer with four waiting requests (R3 not offered)
      for (int k = 0; k < DEPTH; k++) begin
         begin_cyc(); new_req(AW'(8'h10 + k), 1'b0); settle("R3"); tick();
      end
      begin_cyc(); settle("R7");
      chk(full && almost_full && !out_valid, "R7", "four waiting: full, nothing offered",
          FW'({full, almost_full, out_valid}), FW'(3'b110));
      tick();

      // R7: enqueue while full is dropped
      begin_cyc(); new_req(8'h20, 1'b1); settle("R7"); tick();
      begin_cyc(); look_addr = 8'h20; settle("R7");
      chk(!hazard && !out_valid, "R7", "dropped enqueue leaves no trace",
          FW'({hazard, out_valid}), '0);
      tick();

      // R4: fill for one line
      begin_cyc(); fill_valid = 1'b1; fill_addr = 8'h11; settle("R4"); tick();
      begin_cyc(); settle("R4");
      chk(out_valid && out_addr == 8'h11, "R4", "filled line offered",
          FW'({out_valid, out_addr}), FW'({1'b1, 8'h11}));
      sched = 1'b1; tick();

      // R9: in flight is not offered again
      begin_cyc(); look_addr = 8'h11; settle("R9");
      chk(!out_valid && hazard, "R9", "in-flight not offered, still occupied",
          FW'({out_valid, hazard}), FW'(2'b01));
      enq_valid = 1'b1; enq_replay = 1'b1; enq_is_ready = 1'b0; enq_addr = 8'h11;
      tick();

      // R11: re-park keeps one slot, waits for fill
      begin_cyc(); settle("R11");
      chk(!out_valid && full, "R11", "re-parked waits, no new slot",
          FW'({out_valid, full}), FW'(2'b01));
      fill_valid = 1'b1; fill_addr = 8'h11; tick();
      begin_cyc(); settle("R11");
      chk(out_valid && out_addr == 8'h11, "R11", "re-parked offered after fill",
          FW'({out_valid, out_addr}), FW'({1'b1, 8'h11}));
      sched = 1'b1; tick();

      // R10: retire frees the slot
      begin_cyc(); retire = 1'b1; settle("R10"); tick();
      begin_cyc(); look_addr = 8'h11; settle("R10");
      chk(!full && !hazard, "R10", "retired slot freed", FW'({full, hazard}), '0);
      // R5: enqueue with same-line fill in the same cycle
      new_req(8'h21, 1'b0); fill_valid = 1'b1; fill_addr = 8'h21; tick();
      begin_cyc(); settle("R5");
      chk(out_valid && out_addr == 8'h21, "R5", "same-cycle fill makes new entry eligible",
          FW'({out_valid, out_addr}), FW'({1'b1, 8'h21}));
      fill_valid = 1'b1; fill_addr = 8'h12; tick();

      // R8: oldest eligible first
      begin_cyc(); settle("R8");
      chk(out_addr == 8'h12, "R8", "older eligible wins", FW'(out_addr), FW'(8'h12));
      fill_valid = 1'b1; fill_addr = 8'h10; tick();
      begin_cyc(); settle("R8");
      chk(out_addr == 8'h10, "R8", "oldest eligible wins", FW'(out_addr), FW'(8'h10));
      tick();

      // constrained random: small line pool provokes collisions
      for (int c = 0; c < 1500; c++) begin
         int qn;
         begin_cyc();
         qn = m_q.size();
         if (qn > 0 && $urandom_range(0, 99) < 20) retire = 1'b1;
         if ($urandom_range(0, 99) < 45) begin
            new_req(AW'($urandom_range(0, 3)), $urandom_range(0, 99) < 30);
            if (qn > 0 && !retire && $urandom_range(0, 99) < 30) begin
               enq_replay = 1'b1;
               enq_addr   = m_addr[m_q[0]];
            end
         end
         if ($urandom_range(0, 99) < 25) begin
            fill_valid = 1'b1; fill_addr = AW'($urandom_range(0, 3));
         end
         look_addr = AW'($urandom_range(0, 4));
         sched     = ($urandom_range(0, 99) < 40);
         settle("R3 R5 R11 random");
         tick();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule